// File: doc/BRIEF.md
# Dual-Counter PWM Timer Channel

A single timer channel built around two 16-bit down counters that reload by themselves. Counter A sets the PWM period and counter B sets the active time. The output stays high while B is nonzero and goes low once B reaches zero. It stays low until A underflows, and at that point both counters reload. Each underflow of A sets a sticky interrupt flag. The flag is cleared by a write-one strobe and reaches the interrupt output only when the interrupt enable is set.

The count steps come from one of two places. The first is one of three time bases, each arriving as a single-cycle tick-enable pulse in the system clock domain, divided by a prescaler of 1, 4, 16, 64, 256 or 1024. The second is a transition counter on an external input, which is synchronized by two flops and responds to rising edges, falling edges or both. When the channel is disabled, the counters are held at their reload values and the PWM output sits at a programmable idle level. Configuration is expected to change only while the channel is disabled.

Top module: `pwm_tmr_chan`

## Requirements
- R1: `src_sel_i` picks the time base: 0 selects `rtc_tick_i`, 1 selects `ext_tick_i`, 2 selects `bus_tick_i` and 3 selects none. Pulses on the unselected inputs never advance the channel.
- R2: `div_sel_i` values 0 to 5 divide the selected ticks by 1, 4, 16, 64, 256 and 1024. Values 6 and 7 also divide by 1024. Exactly every Nth selected tick becomes a count step, counted from the moment the channel is enabled.
- R3: A count step with A nonzero decrements A. A count step with A equal to zero is an underflow: it loads A with `reload_a_i` and B with `reload_b_i`. The period is therefore `reload_a_i`+1 steps.
- R4: While the channel is enabled, `pwm_o` is 1 exactly when B is nonzero. B decrements on every non-underflow step while it is nonzero and stays at zero otherwise until the next reload.
- R5: If `reload_b_i` is zero, the output is low for the whole period. If `reload_b_i` is greater than `reload_a_i`, the output stays high continuously.
- R6: An underflow sets the interrupt flag, which stays set until a cycle with `irq_clr_i` high. If an underflow and a clear fall in the same cycle, the flag ends up set.
- R7: `irq_o` is the flag ANDed with `irq_en_i`. The flag keeps its value while `irq_en_i` is low.
- R8: While `chan_en_i` is low, A and B follow the reload values, the prescaler restarts, no underflow occurs and `pwm_o` equals `idle_lvl_i`.
- R9: With `edge_en_i` high, the ticks are ignored and each selected transition of `edge_in_i` is one count step. `edge_mode_i` selects the transitions: 0 counts rising, 1 counts falling, and 2 or 3 count both.
- R10: A change on `edge_in_i` that is sampled at a clock edge takes effect on the counters at the second clock edge after that one.
- R11: After reset the counters and the interrupt flag are zero, so `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rtc_tick_i | input | 1 | Real-time clock tick enable |
| ext_tick_i | input | 1 | External clock tick enable |
| bus_tick_i | input | 1 | Bus clock tick enable |
| edge_in_i | input | 1 | Asynchronous input for transition counting |
| chan_en_i | input | 1 | Channel enable |
| src_sel_i | input | 2 | Time base select |
| div_sel_i | input | 3 | Prescaler select |
| edge_en_i | input | 1 | Count input transitions instead of ticks |
| edge_mode_i | input | 2 | Transition type select |
| reload_a_i | input | 16 | Period reload value |
| reload_b_i | input | 16 | Active-time reload value |
| idle_lvl_i | input | 1 | PWM level while disabled |
| irq_en_i | input | 1 | Interrupt output enable |
| irq_clr_i | input | 1 | Write-one strobe that clears the flag |
| pwm_o | output | 1 | PWM output |
| irq_o | output | 1 | Gated interrupt |

## Verification
The checker verifies the following on every cycle:
- The flag is set on an underflow, obeys the clear strobe and is otherwise sticky.
- A decrements by one on each non-underflow step and reloads on underflow.
- B stays at zero once it has reached zero.
- In tick mode, no step happens without a selected tick.
- No underflow happens while the channel is disabled.

Only the bench scenarios can show the quantities that span many cycles: the exact divide ratios, the period and duty seen at the pin, the selection among transition types, the synchronizer latency and the idle level.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;
  localparam int unsigned CNT_W        = 16;
  localparam int unsigned NUM_SRC      = 3;
  localparam int unsigned DIV_STEPS    = 6;
  localparam int unsigned DIV_LOG_STEP = 2;
  localparam int unsigned PRESC_W      = DIV_LOG_STEP * (DIV_STEPS - 1);

  typedef enum logic [1:0] {
    SRC_RTC  = 2'd0,
    SRC_EXT  = 2'd1,
    SRC_BUS  = 2'd2,
    SRC_NONE = 2'd3
  } src_sel_e;

  typedef enum logic [1:0] {
    EDGE_RISE  = 2'd0,
    EDGE_FALL  = 2'd1,
    EDGE_BOTH  = 2'd2,
    EDGE_BOTH2 = 2'd3
  } edge_mode_e;

  function automatic logic [PRESC_W-1:0] div_limit(input logic [2:0] sel);
    int unsigned s;
    s = (int'(sel) > DIV_STEPS - 1) ? DIV_STEPS - 1 : int'(sel);
    return PRESC_W'((1 << (DIV_LOG_STEP * s)) - 1);
  endfunction
endpackage

// File: rtl/pwm_tick_presc.sv
module pwm_tick_presc
  import pwm_tmr_pkg::*;
#(
  parameter int unsigned N_SRC = NUM_SRC,
  parameter int unsigned PW    = PRESC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [N_SRC-1:0] ticks_i,
  input  logic [1:0]       sel_i,
  input  logic [2:0]       div_sel_i,
  output logic             src_tick_o,
  output logic [PW-1:0]    cnt_o,
  output logic [PW-1:0]    lim_o,
  output logic             step_o
);
  logic [N_SRC-1:0] hit_vec;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign hit_vec[g] = ticks_i[g] && (int'(sel_i) == g);
  end

  logic [PW-1:0] cnt_q;
  logic          wrap;

  assign src_tick_o = |hit_vec;
  assign lim_o      = PW'(div_limit(div_sel_i));
  assign wrap       = (cnt_q >= lim_o);
  assign step_o     = src_tick_o && wrap;
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (clr_i)      cnt_q <= '0;
    else if (src_tick_o) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/pwm_edge_cnt.sv
module pwm_edge_cnt
  import pwm_tmr_pkg::*;
#(
  parameter int unsigned SYNC_N = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       edge_i,
  input  logic [1:0] mode_i,
  output logic       pulse_o
);
  logic [SYNC_N:0] chain_q;

  for (genvar g = 0; g <= SYNC_N; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[0] <= 1'b0;
        else         chain_q[0] <= edge_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= 1'b0;
        else         chain_q[g] <= chain_q[g-1];
      end
    end
  end

  logic cur, prv, rise, fall;
  assign cur  = chain_q[SYNC_N-1];
  assign prv  = chain_q[SYNC_N];
  assign rise = cur && !prv;
  assign fall = !cur && prv;

  always_comb begin
    unique case (edge_mode_e'(mode_i))
      EDGE_RISE: pulse_o = rise;
      EDGE_FALL: pulse_o = fall;
      default:   pulse_o = rise || fall;
    endcase
  end
endmodule

// File: rtl/pwm_ab_core.sv
module pwm_ab_core
  import pwm_tmr_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] reload_a_i,
  input  logic [W-1:0] reload_b_i,
  output logic [W-1:0] a_cnt_o,
  output logic [W-1:0] b_cnt_o,
  output logic         uf_o
);
  logic [W-1:0] a_q, b_q;

  assign uf_o    = !load_i && step_i && (a_q == '0);
  assign a_cnt_o = a_q;
  assign b_cnt_o = b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
    end else if (load_i || uf_o) begin
      a_q <= reload_a_i;
      b_q <= reload_b_i;
    end else if (step_i) begin
      a_q <= a_q - 1'b1;
      if (b_q != '0) b_q <= b_q - 1'b1;
    end
  end
endmodule

// File: rtl/pwm_tmr_chan.sv
module pwm_tmr_chan
  import pwm_tmr_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rtc_tick_i,
  input  logic        ext_tick_i,
  input  logic        bus_tick_i,
  input  logic        edge_in_i,
  input  logic        chan_en_i,
  input  logic [1:0]  src_sel_i,
  input  logic [2:0]  div_sel_i,
  input  logic        edge_en_i,
  input  logic [1:0]  edge_mode_i,
  input  logic [15:0] reload_a_i,
  input  logic [15:0] reload_b_i,
  input  logic        idle_lvl_i,
  input  logic        irq_en_i,
  input  logic        irq_clr_i,
  output logic        pwm_o,
  output logic        irq_o
);
  logic [NUM_SRC-1:0] ticks;
  logic               src_tick, presc_step, edge_pulse, step, uf;
  logic [PRESC_W-1:0] presc_cnt, presc_lim;
  logic [CNT_W-1:0]   a_cnt, b_cnt;
  logic               irq_flag_q;

  assign ticks = {bus_tick_i, ext_tick_i, rtc_tick_i};

  pwm_tick_presc u_presc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (!chan_en_i || edge_en_i),
    .ticks_i    (ticks),
    .sel_i      (src_sel_i),
    .div_sel_i  (div_sel_i),
    .src_tick_o (src_tick),
    .cnt_o      (presc_cnt),
    .lim_o      (presc_lim),
    .step_o     (presc_step)
  );

  pwm_edge_cnt u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .edge_i  (edge_in_i),
    .mode_i  (edge_mode_i),
    .pulse_o (edge_pulse)
  );

  assign step = edge_en_i ? edge_pulse : presc_step;

  pwm_ab_core u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (!chan_en_i),
    .step_i     (step),
    .reload_a_i (reload_a_i),
    .reload_b_i (reload_b_i),
    .a_cnt_o    (a_cnt),
    .b_cnt_o    (b_cnt),
    .uf_o       (uf)
  );

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        irq_flag_q <= 1'b0;
    else if (uf)        irq_flag_q <= 1'b1;
    else if (irq_clr_i) irq_flag_q <= 1'b0;
  end

  assign irq_o = irq_flag_q && irq_en_i;
  assign pwm_o = chan_en_i ? (b_cnt != '0) : idle_lvl_i;
endmodule

// File: rtl/pwm_tmr_chan_chk.sv
module pwm_tmr_chan_chk
  import pwm_tmr_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             chan_en_i,
  input logic             edge_en_i,
  input logic             irq_clr_i,
  input logic             uf,
  input logic             step,
  input logic             src_tick,
  input logic             irq_flag_q,
  input logic [CNT_W-1:0] a_cnt,
  input logic [CNT_W-1:0] b_cnt,
  input logic [CNT_W-1:0] reload_a_i
);
  a_r6_set_on_uf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf |=> irq_flag_q);

  a_r6_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_clr_i && !uf) |=> !irq_flag_q);

  a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_flag_q && !irq_clr_i) |=> irq_flag_q);

  a_r3_a_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_en_i && step && a_cnt != '0) |=> (a_cnt == $past(a_cnt) - 1'b1));

  a_r3_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf |=> (a_cnt == $past(reload_a_i)));

  a_r4_b_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_en_i && b_cnt == '0 && !uf) |=> (b_cnt == '0));

  a_r1_step_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!edge_en_i && step) |-> src_tick);

  a_r8_no_uf_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chan_en_i |-> !uf);
endmodule

bind pwm_tmr_chan pwm_tmr_chan_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .chan_en_i  (chan_en_i),
  .edge_en_i  (edge_en_i),
  .irq_clr_i  (irq_clr_i),
  .uf         (uf),
  .step       (step),
  .src_tick   (src_tick),
  .irq_flag_q (irq_flag_q),
  .a_cnt      (a_cnt),
  .b_cnt      (b_cnt),
  .reload_a_i (reload_a_i)
);

// File: tb/pwm_tmr_chan_tb_top.sv
module pwm_tmr_chan_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic rtc_t = 0, ext_t = 0, bus_t = 0, ein = 0, en = 0, edge_en = 0;
  logic [1:0] ssel = 0, emode = 0;
  logic [2:0] dsel = 0;
  logic [15:0] ra = 0, rb = 0;
  logic idle = 0, ien = 0, clr = 0;
  logic pwm, irq;

  pwm_tmr_chan dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rtc_tick_i(rtc_t), .ext_tick_i(ext_t),
    .bus_tick_i(bus_t), .edge_in_i(ein), .chan_en_i(en), .src_sel_i(ssel),
    .div_sel_i(dsel), .edge_en_i(edge_en), .edge_mode_i(emode),
    .reload_a_i(ra), .reload_b_i(rb), .idle_lvl_i(idle), .irq_en_i(ien),
    .irq_clr_i(clr), .pwm_o(pwm), .irq_o(irq)
  );

  int n_chk = 0, n_bad = 0;
  int unsigned m_a = 0, m_b = 0, m_p = 0;
  logic m_flag = 0, h1 = 0, h2 = 0, h3 = 0;

  function automatic int unsigned ratio(input logic [2:0] s);
    int unsigned k;
    k = (s > 5) ? 5 : s;
    return 1 << (2 * k);
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // reference update for one clock edge, from the requirements
  task automatic model_edge();
    logic tick, stp, rise, fall;
    stp  = 0;
    rise = h2 && !h3;
    fall = !h2 && h3;
    tick = (ssel == 0 && rtc_t) || (ssel == 1 && ext_t) || (ssel == 2 && bus_t);
    if (!en) begin
      m_a = ra; m_b = rb; m_p = 0;
      if (clr) m_flag = 0;
    end else begin
      if (edge_en) begin
        m_p = 0;
        stp = (emode == 0) ? rise : (emode == 1) ? fall : (rise || fall);
      end else if (tick) begin
        if (m_p == ratio(dsel) - 1) begin stp = 1; m_p = 0; end
        else m_p++;
      end
      if (stp && m_a == 0) begin
        m_a = ra; m_b = rb; m_flag = 1;
      end else begin
        if (stp) begin
          m_a--;
          if (m_b != 0) m_b--;
        end
        if (clr) m_flag = 0;
      end
    end
    h3 = h2; h2 = h1; h1 = ein;
  endtask

  task automatic cyc(input logic r, input logic e, input logic b,
                     input logic ei, input logic c);
    @(negedge clk);
    rtc_t = r; ext_t = e; bus_t = b; ein = ei; clr = c;
    @(posedge clk);
    model_edge();
    #1;
    chk("R4 pwm", pwm, en ? (m_b != 0) : idle);
    chk("R6/R7 irq", irq, m_flag && ien);
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, ein, 0);
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R11 reset irq", irq, 0);
    chk("R11 reset pwm idle", pwm, 0);
    @(negedge clk); rst_n = 1;

    // R3/R4: period 4, duty 1, bus ticks every cycle, ratio 1
    ssel = 2; dsel = 0; ra = 3; rb = 1; ien = 1;
    idle_cycles(2);
    en = 1;
    for (int i = 0; i < 12; i++) cyc(0, 0, 1, 0, 0);
    chk("R3 underflow flag seen", irq, 1);
    cyc(0, 0, 0, 0, 1);
    chk("R6 clear", irq, 0);

    // R1: unselected sources do not advance
    en = 0; ssel = 1; ra = 1; rb = 1; idle_cycles(2); en = 1;
    for (int i = 0; i < 10; i++) cyc(1, 0, 1, 0, 0);
    chk("R1 unselected ticks ignored pwm", pwm, 1);
    chk("R1 unselected ticks ignored irq", irq, 0);
    cyc(0, 1, 0, 0, 0);
    chk("R1 selected tick advances", pwm, 0);

    // R2: divide by 4 and by 1024 (select 7)
    en = 0; ssel = 0; dsel = 1; ra = 0; rb = 0; idle_cycles(2); en = 1;
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 0);
    chk("R2 div4 before", irq, 0);
    cyc(1, 0, 0, 0, 0);
    chk("R2 div4 at 4th", irq, 1);
    en = 0; dsel = 7; idle_cycles(1); cyc(0, 0, 0, 0, 1); en = 1;
    for (int i = 0; i < 1023; i++) cyc(1, 0, 0, 0, 0);
    chk("R2 div1024 before", irq, 0);
    cyc(1, 0, 0, 0, 0);
    chk("R2 div1024 at 1024th", irq, 1);

    // R6: set wins over simultaneous clear
    en = 0; dsel = 0; idle_cycles(1); en = 1;
    cyc(1, 0, 0, 0, 1);
    chk("R6 set beats clear", irq, 1);

    // R7: gated output, flag retained
    ien = 0; cyc(0, 0, 0, 0, 0);
    chk("R7 gated", irq, 0);
    ien = 1; cyc(0, 0, 0, 0, 0);
    chk("R7 flag kept", irq, 1);

    // R5: B = 0 always low, B > A always high
    en = 0; ra = 2; rb = 0; idle_cycles(1); en = 1;
    for (int i = 0; i < 7; i++) begin cyc(1, 0, 0, 0, 0); chk("R5 low", pwm, 0); end
    en = 0; ra = 2; rb = 5; idle_cycles(1); en = 1;
    for (int i = 0; i < 7; i++) begin cyc(1, 0, 0, 0, 0); chk("R5 high", pwm, 1); end

    // R8: disabled, idle level, ticks ignored
    en = 0; idle = 1; ra = 0; cyc(0, 0, 0, 0, 1);
    for (int i = 0; i < 6; i++) cyc(1, 1, 1, 0, 0);
    chk("R8 idle level", pwm, 1);
    chk("R8 no underflow", irq, 0);
    idle = 0;

    // R9/R10: rising edges, latency
    ssel = 3; edge_en = 1; emode = 0; ra = 0; rb = 0;
    idle_cycles(4); en = 1;
    cyc(0, 0, 0, 1, 0);
    chk("R10 +0", irq, 0);
    cyc(0, 0, 0, 1, 0);
    chk("R10 +1", irq, 0);
    cyc(0, 0, 0, 1, 0);
    chk("R10 +2", irq, 1);
    cyc(0, 0, 0, 1, 1);
    cyc(0, 0, 0, 0, 0); idle_cycles(4);
    chk("R9 falling ignored in rise mode", irq, 0);
    for (int i = 0; i < 30; i++) cyc(1, 1, 1, ein, 0);
    chk("R9 ticks ignored", irq, 0);

    // random configurations
    for (int k = 0; k < 40; k++) begin
      en = 0;
      ssel = 2'($urandom_range(0, 3)); dsel = 3'($urandom_range(0, 2));
      edge_en = ($urandom_range(0, 3) == 0); emode = 2'($urandom_range(0, 3));
      ra = 16'($urandom_range(0, 7)); rb = 16'($urandom_range(0, 9));
      idle = 1'($urandom_range(0, 1)); ien = 1'($urandom_range(0, 1));
      idle_cycles(5);
      en = 1;
      for (int i = 0; i < 150; i++)
        cyc(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
            ($urandom_range(0, 4) == 0) ? ~ein : ein, ($urandom_range(0, 9) == 0));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule